// File: doc/BRIEF.md
# ADC Sample Histogram Accumulator

This block builds a code-occupancy histogram from a stream of 12-bit converter samples. It holds one 16-bit count word for each of the 4096 possible codes. Each accepted sample is used as a memory address: the block reads the count stored there, adds one, and writes the sum back to the same location. The memory is built from two 8-bit halves, and the two halves together form each count.

A run begins with a start pulse. The block first writes zero to every location, then raises `ready` and takes samples marked by `s_valid`. After exactly 65536 samples it stops taking samples. When the last write has landed it raises `done`. While `done` is high, the host reads counts through a simple request/response port with a latency of one clock. A synchronous reset returns the controller to idle but leaves the memory contents unchanged.

Top module: `hist_accum`

## Requirements
- R1: A `start` pulse while idle or done begins a clear pass. `ready` stays low for exactly 4096 cycles after the start edge while every location is written with zero, and then goes high.
- R2: A sample is taken only when `s_valid` and `ready` are both high. Samples presented during clearing, while idle, or while done leave every count unchanged.
- R3: Each accepted sample adds one to the count at the address equal to its 12-bit value. The 16-bit count is formed as {upper half, lower half}, with the lower 8-bit half in bits 7:0.
- R4: Samples accepted on consecutive cycles lose no increment, whether they carry the same code or different codes.
- R5: A count stops at 16'hFFFF and does not wrap. When all 65536 samples of a run carry one code, that location reads 16'hFFFF.
- R6: A run accepts exactly 65536 samples. `ready` stays high until the 65536th sample is accepted and is low in the cycle after that acceptance.
- R7: `done` rises at the second rising edge after the edge that accepts the final sample. It stays high until the next `start` and is low in the cycle after that start.
- R8: While `done` is high, a `rd_req` with `rd_addr` produces `rd_valid` high and the count in `rd_count` one clock later. A `rd_req` while `done` is low produces no `rd_valid`.
- R9: A synchronous active-high `rst` leaves `ready`, `done` and `rd_valid` low and the controller idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new clear-and-accumulate run |
| s_valid | input | 1 | Sample strobe |
| s_code | input | 12 | Sample value from the converter |
| ready | output | 1 | High while samples are being taken |
| done | output | 1 | Run complete; counts may be read |
| rd_req | input | 1 | Host read request |
| rd_addr | input | 12 | Code whose count is requested |
| rd_valid | output | 1 | `rd_count` holds the requested count |
| rd_count | output | 16 | Count read back |

## Verification
The bench sends bursts of identical codes on back-to-back cycles. A design that reads the memory value before the previous increment to that address has landed would return counts that are too low. A second run feeds all 65536 samples with a single code, so a counter that wraps would read back zero and a fault in the upper half would show in the top byte. Samples are held valid through the clear pass, after the last accepted sample, and while `done` is high; a design that takes them would show extra counts at code 0x7FF or 0x123. The bench times `ready` dropping and `done` rising to the exact cycle, so an off-by-one in the sample counter or the pipeline drain is caught.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Controller phases of one accumulation run
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } hist_state_e;

endpackage

// File: rtl/hist_bank.sv
// One slice of the count memory: synchronous write, registered read.
module hist_bank #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // A read of the address being written returns the old contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_ctrl.sv
// Run sequencer: clear walk, sample acceptance and counting, drain, done.
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int AW      = 12,
  parameter int RUN_LEN = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          s_valid,
  input  logic          pipe_busy,
  output logic          ready,
  output logic          accept,
  output logic          done,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [AW-1:0]    CLR_LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

  hist_state_e      state;
  logic [CNT_W-1:0] scount;

  // Named events for the assertions
  logic clear_last;
  logic run_last;
  logic start_ok;

  always_comb begin
    ready      = (state == ST_RUN);
    accept     = ready && s_valid;
    done       = (state == ST_DONE);
    clr_we     = (state == ST_CLEAR);
    clear_last = clr_we && (clr_addr == CLR_LAST);
    run_last   = accept && (scount == RUN_LAST);
    start_ok   = start && ((state == ST_IDLE) || (state == ST_DONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      clr_addr <= '0;
      scount   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state    <= ST_CLEAR;
            clr_addr <= '0;
            scount   <= '0;
          end
        end
        ST_CLEAR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clear_last) state <= ST_RUN;
        end
        ST_RUN: begin
          if (accept) scount <= scount + 1'b1;
          if (run_last) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!pipe_busy) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the clear walk steps one address per cycle
  assert_clear_walk_R1: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !clear_last) |=> (clr_we && clr_addr == $past(clr_addr) + 1'b1));

  // R1: sampling only opens after the last address was cleared
  assert_clear_to_run_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_CLEAR) |-> ($past(clr_addr) == CLR_LAST));

  // R6: the sample counter never passes the run length
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    scount <= CNT_W'(RUN_LEN));

  // R7: done persists until a start arrives
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: rtl/hist_rmw.sv
// Read-modify-write stage with one-deep forwarding of the last written count.
module hist_rmw #(
  parameter int AW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] code,
  input  logic [CW-1:0] mem_q,
  output logic          inc_we,
  output logic [AW-1:0] inc_addr,
  output logic [CW-1:0] inc_data,
  output logic          busy
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  // Saturating increment of one count word
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic          p1_vld;
  logic [AW-1:0] p1_addr;
  logic          wb_vld;
  logic [AW-1:0] wb_addr;
  logic [CW-1:0] wb_data;
  logic          fwd_hit;
  logic [CW-1:0] base;

  always_comb begin
    fwd_hit  = wb_vld && (wb_addr == p1_addr);
    base     = fwd_hit ? wb_data : mem_q;
    inc_data = sat_inc(base);
    inc_we   = p1_vld;
    inc_addr = p1_addr;
    busy     = p1_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_vld <= 1'b0;
      wb_vld <= 1'b0;
    end else begin
      p1_vld <= accept;
      wb_vld <= p1_vld;
    end
    p1_addr <= code;
    wb_addr <= p1_addr;
    wb_data <= inc_data;
  end

  // R5: a written count is never zero, so it never wraps
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    inc_we |-> (inc_data != '0));

  // R4: two writes in a row to one address differ by exactly one unless saturated
  assert_repeat_step_R4: assert property (@(posedge clk) disable iff (rst)
    (inc_we && $past(inc_we) && inc_addr == $past(inc_addr))
      |-> (inc_data == $past(inc_data) + 1'b1 || inc_data == CNT_MAX));
endmodule

// File: rtl/hist_accum.sv
// Histogram accumulator top: controller, RMW stage and split count memory.
module hist_accum #(
  parameter int AW       = 12,
  parameter int HALF_W   = 8,
  parameter int NUM_HALF = 2,
  parameter int RUN_LEN  = 65536
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       s_valid,
  input  logic [AW-1:0]              s_code,
  output logic                       ready,
  output logic                       done,
  input  logic                       rd_req,
  input  logic [AW-1:0]              rd_addr,
  output logic                       rd_valid,
  output logic [HALF_W*NUM_HALF-1:0] rd_count
);
  localparam int CW = HALF_W * NUM_HALF;

  logic          accept;
  logic          clr_we;
  logic [AW-1:0] clr_addr;
  logic          inc_we;
  logic [AW-1:0] inc_addr;
  logic [CW-1:0] inc_data;
  logic          pipe_busy;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [CW-1:0] mem_wdata;
  logic [AW-1:0] mem_raddr;
  logic [CW-1:0] mem_q;

  hist_ctrl #(.AW(AW), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .s_valid  (s_valid),
    .pipe_busy(pipe_busy),
    .ready    (ready),
    .accept   (accept),
    .done     (done),
    .clr_we   (clr_we),
    .clr_addr (clr_addr)
  );

  hist_rmw #(.AW(AW), .CW(CW)) u_rmw (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .code    (s_code),
    .mem_q   (mem_q),
    .inc_we  (inc_we),
    .inc_addr(inc_addr),
    .inc_data(inc_data),
    .busy    (pipe_busy)
  );

  // Write port: clearing and incrementing never overlap in time
  always_comb begin
    mem_we    = clr_we || inc_we;
    mem_waddr = clr_we ? clr_addr : inc_addr;
    mem_wdata = clr_we ? '0 : inc_data;
    mem_raddr = done ? rd_addr : s_code;
  end

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    hist_bank #(.AW(AW), .DW(HALF_W)) u_bank (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata[g*HALF_W +: HALF_W]),
      .raddr(mem_raddr),
      .rdata(mem_q[g*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= done && rd_req;
  end

  assign rd_count = mem_q;

  // R3: every increment write traces back to an accepted sample one cycle earlier
  assert_inc_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    inc_we |-> $past(accept));

  // R1: clear writes and increment writes are exclusive
  assert_clear_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(clr_we && inc_we));

  // R2: nothing is written to the memory while the run is finished
  assert_quiet_done_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);
endmodule

// File: tb/hist_accum_tb.sv
module hist_accum_tb;
  localparam int NCODE = 4096;
  localparam int NRUN  = 65536;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        s_valid;
  logic [11:0] s_code;
  logic        ready;
  logic        done;
  logic        rd_req;
  logic [11:0] rd_addr;
  logic        rd_valid;
  logic [15:0] rd_count;

  hist_accum u_dut (
    .clk(clk), .rst(rst), .start(start), .s_valid(s_valid), .s_code(s_code),
    .ready(ready), .done(done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_count(rd_count)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit finished = 0;
  int exp_cnt [NCODE];

  typedef struct {
    int addr;
    int expv;
    int cyc;
    bit sat;
  } rd_item_t;
  rd_item_t sb_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 195000);
      finish_up();
    end
  end

  // Monitor: pops expected reads and compares
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "rd_valid with no request while done", 1, 0);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(cyc == it.cyc + 1, "R8", "read latency", cyc - it.cyc, 1);
        if (it.sat)
          chk(rd_count == 16'(it.expv), "R5", $sformatf("count @%0h", it.addr),
              int'(rd_count), it.expv);
        else
          chk(rd_count == 16'(it.expv), "R3", $sformatf("count @%0h", it.addr),
              int'(rd_count), it.expv);
      end
    end
  end

  function automatic int pat_code(input int i, input int prev);
    if (i > 0 && (i % 16) < 5) return prev;   // bursts of equal codes (R4)
    if ((i % 16) == 9) return (prev ^ 12'h001) % NCODE;
    return (i * 37 + i / 64) % NCODE;
  endfunction

  task automatic run_pass(input int mode);
    int n;
    int acc;
    int i;
    int prev;
    int code;
    bit v;
    bit early;
    foreach (exp_cnt[k]) exp_cnt[k] = 0;
    @(negedge clk);
    start = 1'b1; s_valid = 1'b1; s_code = 12'h7FF; rd_req = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7", "done low after start", int'(done), 0);
    rd_req = 1'b1; rd_addr = 12'h000;   // must be ignored while not done (R8)
    n = 0;
    while (!ready && n < 10000) begin
      n++;
      @(negedge clk);
    end
    rd_req = 1'b0;
    chk(n == NCODE, "R1", "clear length in cycles", n, NCODE);
    acc = 0; i = 0; prev = 0; early = 0;
    while (acc < NRUN) begin
      if (mode == 2) begin
        code = 12'h5A5; v = 1'b1;
      end else begin
        code = pat_code(i, prev);
        v = ((i % 11) != 10);
      end
      prev = code;
      s_valid = v; s_code = 12'(code);
      if (!ready) early = 1;
      if (v && ready) begin
        if (exp_cnt[code] < 65535) exp_cnt[code]++;
        acc++;
      end
      i++;
      @(negedge clk);
    end
    chk(!early, "R6", "ready dropped before run end", int'(early), 0);
    s_valid = 1'b1; s_code = 12'h7FF;   // ignored (R2)
    chk(ready == 1'b0, "R6", "ready after last sample", int'(ready), 0);
    chk(done == 1'b0, "R7", "done one cycle after last", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done two cycles after last", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R7", "done at second edge after last", int'(done), 1);
    // Samples while done are ignored (R2)
    s_code = 12'h123;
    repeat (20) @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic read_all(input bit sat);
    for (int a = 0; a < NCODE; a++) begin
      rd_item_t it;
      rd_req = 1'b1; rd_addr = 12'(a);
      it.addr = a; it.expv = exp_cnt[a]; it.cyc = cyc; it.sat = sat;
      sb_q.push_back(it);
      @(negedge clk);
    end
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R8", "all reads answered", sb_q.size(), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; s_valid = 1'b0; s_code = '0;
    rd_req = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    chk(ready == 1'b0, "R9", "ready in reset", int'(ready), 0);
    chk(done == 1'b0, "R9", "done in reset", int'(done), 0);
    chk(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
    rst = 1'b0;
    s_valid = 1'b1; s_code = 12'h7FF;   // idle samples ignored (R2)
    @(negedge clk);
    chk(ready == 1'b0, "R9", "idle after reset", int'(ready), 0);

    run_pass(1);
    read_all(1'b0);
    chk(done == 1'b1, "R7", "done held through readback", int'(done), 1);
    chk(exp_cnt[12'h7FF] < 1000, "R2", "guard code count sane", exp_cnt[12'h7FF], 0);

    run_pass(2);
    chk(exp_cnt[12'h5A5] == 65535, "R5", "bench model saturates", exp_cnt[12'h5A5], 65535);
    read_all(1'b1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done cleared by reset", int'(done), 0);
    chk(ready == 1'b0, "R9", "ready low after reset", int'(ready), 0);
    finish_up();
  end
endmodule